// File: doc/BRIEF.md
# Page-Crossing Request Splitter with Address Translation

This block takes one memory request at a time from a graphics port. A request is a start address, a byte length and a read/write bit. The block first checks the request against the legal size set and the 8-byte alignment rule. It then works out whether the request runs past the end of its 4 KB page, and cuts it into one or two sub-requests that never leave a page.

Each sub-request is translated on its own. Pages inside a 16-page remapping window are looked up in an external table through a synchronous lookup port, which returns a physical page number and a coherent bit one cycle after the index is presented. Pages outside the window pass through with their address unchanged and a fixed coherent attribute.

Because the two halves of a split request are translated separately, they can land on physical pages that are not adjacent, and they can carry different coherency. A request that breaks the rules produces no sub-requests and raises a one-cycle illegal flag.

Top module: `xlat_splitter`

## Requirements
- R1: A length is legal when it is a multiple of 8 from 8 to 64, or a multiple of 32 from 32 to 256; any other length is illegal (for example 0, 12, 72 or 288).
- R2: A start address whose low three bits are not all zero is illegal, whatever the length.
- R3: An illegal request is accepted, sets err_illegal high for exactly the cycle after the accepting edge, and produces no sub-request.
- R4: A legal request that fits in its 4 KB page (offset plus length at most 4096) yields one sub-request with the full length and sub_last = 1.
- R5: A legal request that crosses a page end yields two sub-requests in address order. The first has length 4096 minus the page offset and sub_last = 0. The second starts at offset 0 of the next page, carries the remaining bytes, and has sub_last = 1.
- R6: A page number p with 0 <= p - WIN_PAGE < 16 is in the window. Its table index is p - WIN_PAGE, and the sub-request address is the returned physical page followed by the unchanged 12-bit offset, with sub_coh equal to the returned coherent bit.
- R7: Each part of a split request is looked up separately, so the two parts may carry non-adjacent physical pages and different sub_coh values. This also holds when only one part lies in the window.
- R8: A page outside the window issues no lookup; its sub-request address equals the untranslated address and sub_coh equals BYPASS_COH (default 1).
- R9: While sub_valid is high and sub_ready is low, sub_valid, sub_addr, sub_len, sub_coh and sub_last hold their values.
- R10: req_ready is low from the edge that accepts a legal request until the edge that accepts its last sub-request; sub_write echoes the request's write bit.
- R11: After reset, req_ready = 1, and sub_valid, err_illegal and lk_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Request start address (bytes) |
| req_len | input | LEN_W | Request length in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| sub_valid | output | 1 | Sub-request offered |
| sub_ready | input | 1 | Consumer takes the sub-request |
| sub_addr | output | ADDR_W | Physical address of the sub-request |
| sub_len | output | LEN_W | Sub-request length in bytes |
| sub_write | output | 1 | Write bit of the parent request |
| sub_coh | output | 1 | Coherency attribute of the sub-request |
| sub_last | output | 1 | Final sub-request of the parent |
| err_illegal | output | 1 | One-cycle pulse for a rejected request |
| lk_req | output | 1 | Lookup strobe |
| lk_idx | output | IDX_W | Lookup table index |
| lk_page | input | ADDR_W-PAGE_W | Physical page returned one cycle after lk_req |
| lk_coh | input | 1 | Coherent bit returned one cycle after lk_req |

## Verification
The checker watches, on every cycle, the properties that hold for any traffic. It checks that an offered sub-request stays frozen under backpressure and never runs past its page end. It also checks that its length is a non-zero multiple of 8, that no request is taken while one is in flight, and that the illegal flag only follows an accepting edge. The bench's scenarios are needed for the arithmetic that the checker does not model. These are the split point and the remainder for offsets just short of a page end, the exact translated pages and attributes drawn from the table, and the window edge where one half is translated and the other bypassed. They also cover the legal-size set itself.

// File: rtl/xsplit_pkg.sv
package xsplit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_LOAD = 2'd2,
    ST_SEND = 2'd3
  } st_e;

  // Legal byte counts: fine grain 8..64 step 8, coarse grain 32..256 step 32.
  function automatic logic size_ok(input int unsigned n);
    logic fine;
    logic coarse;
    fine   = (n >= 8)  && (n <= 64)  && ((n % 8)  == 0);
    coarse = (n >= 32) && (n <= 256) && ((n % 32) == 0);
    return fine || coarse;
  endfunction

endpackage

// File: rtl/xsplit_req_check.sv
module xsplit_req_check
  import xsplit_pkg::*;
#(
  parameter int LEN_W = 9
) (
  input  logic [2:0]       addr_lo,
  input  logic [LEN_W-1:0] len,
  output logic             legal
);

  always_comb begin
    legal = size_ok(32'(len)) && (addr_lo == 3'b000);
  end

endmodule

// File: rtl/xsplit_page_split.sv
module xsplit_page_split #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int LEN_W  = 9
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  total_len,
  input  logic              part,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  cur_len,
  output logic              two_part
);

  localparam int VPN_W = ADDR_W - PAGE_W;
  localparam int RW    = PAGE_W + 1;

  logic [RW-1:0]    room;
  logic [RW-1:0]    len_x;
  logic [VPN_W-1:0] next_vpn;

  always_comb begin
    room     = RW'(1 << PAGE_W) - {1'b0, base_addr[PAGE_W-1:0]};
    len_x    = RW'(total_len);
    two_part = len_x > room;
    next_vpn = base_addr[ADDR_W-1:PAGE_W] + VPN_W'(1);
    if (!part) begin
      cur_addr = base_addr;
      cur_len  = two_part ? LEN_W'(room) : total_len;
    end else begin
      cur_addr = {next_vpn, {PAGE_W{1'b0}}};
      cur_len  = LEN_W'(len_x - room);
    end
  end

endmodule

// File: rtl/xsplit_xlate.sv
module xsplit_xlate #(
  parameter int          ADDR_W     = 32,
  parameter int          PAGE_W     = 12,
  parameter int          TBL_DEPTH  = 16,
  parameter int unsigned WIN_PAGE   = 32'h10000,
  parameter logic        BYPASS_COH = 1'b1,
  localparam int         VPN_W      = ADDR_W - PAGE_W,
  localparam int         IDX_W      = $clog2(TBL_DEPTH)
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [VPN_W-1:0]  lk_page,
  input  logic              lk_coh,
  output logic              in_win,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              coh
);

  logic [VPN_W-1:0] rel;

  always_comb begin
    rel    = cur_addr[ADDR_W-1:PAGE_W] - VPN_W'(WIN_PAGE);
    in_win = rel < VPN_W'(TBL_DEPTH);
    idx    = rel[IDX_W-1:0];
    if (in_win) begin
      phys_addr = {lk_page, cur_addr[PAGE_W-1:0]};
      coh       = lk_coh;
    end else begin
      phys_addr = cur_addr;
      coh       = BYPASS_COH;
    end
  end

endmodule

// File: rtl/xlat_splitter.sv
module xlat_splitter
  import xsplit_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          PAGE_W     = 12,
  parameter int          LEN_W      = 9,
  parameter int          TBL_DEPTH  = 16,
  parameter int unsigned WIN_PAGE   = 32'h10000,
  parameter logic        BYPASS_COH = 1'b1,
  localparam int         VPN_W      = ADDR_W - PAGE_W,
  localparam int         IDX_W      = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  output logic              sub_valid,
  input  logic              sub_ready,
  output logic [ADDR_W-1:0] sub_addr,
  output logic [LEN_W-1:0]  sub_len,
  output logic              sub_write,
  output logic              sub_coh,
  output logic              sub_last,
  output logic              err_illegal,
  output logic              lk_req,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic [VPN_W-1:0]  lk_page,
  input  logic              lk_coh
);

  // State and captured request
  st_e               state_q, state_d;
  logic              part_q, part_d;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              wr_q;
  logic              err_q, err_d;

  // Sub-request output registers
  logic              sv_q, sv_d;
  logic [ADDR_W-1:0] sa_q;
  logic [LEN_W-1:0]  sl_q;
  logic              sc_q;
  logic              slast_q;

  // Enables
  logic req_en;
  logic sub_en;

  // Datapath nets
  logic              legal;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cur_len;
  logic              two_part;
  logic              in_win;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] phys_addr;
  logic              phys_coh;

  xsplit_req_check #(.LEN_W(LEN_W)) u_check (
    .addr_lo (req_addr[2:0]),
    .len     (req_len),
    .legal   (legal)
  );

  xsplit_page_split #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .LEN_W  (LEN_W)
  ) u_split (
    .base_addr (addr_q),
    .total_len (len_q),
    .part      (part_q),
    .cur_addr  (cur_addr),
    .cur_len   (cur_len),
    .two_part  (two_part)
  );

  xsplit_xlate #(
    .ADDR_W     (ADDR_W),
    .PAGE_W     (PAGE_W),
    .TBL_DEPTH  (TBL_DEPTH),
    .WIN_PAGE   (WIN_PAGE),
    .BYPASS_COH (BYPASS_COH)
  ) u_xlate (
    .cur_addr  (cur_addr),
    .lk_page   (lk_page),
    .lk_coh    (lk_coh),
    .in_win    (in_win),
    .idx       (idx),
    .phys_addr (phys_addr),
    .coh       (phys_coh)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    part_d  = part_q;
    err_d   = 1'b0;
    sv_d    = sv_q;
    req_en  = 1'b0;
    sub_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (legal) begin
            req_en  = 1'b1;
            part_d  = 1'b0;
            state_d = ST_LOOK;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_LOOK: state_d = ST_LOAD;
      ST_LOAD: begin
        sub_en  = 1'b1;
        sv_d    = 1'b1;
        state_d = ST_SEND;
      end
      ST_SEND: begin
        if (sub_ready) begin
          sv_d = 1'b0;
          if (slast_q) begin
            state_d = ST_IDLE;
          end else begin
            part_d  = 1'b1;
            state_d = ST_LOOK;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      part_q  <= 1'b0;
      err_q   <= 1'b0;
      sv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      part_q  <= part_d;
      err_q   <= err_d;
      sv_q    <= sv_d;
    end
  end

  // Request capture registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
      wr_q   <= 1'b0;
    end else if (req_en) begin
      addr_q <= req_addr;
      len_q  <= req_len;
      wr_q   <= req_write;
    end
  end

  // Sub-request payload registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q    <= '0;
      sl_q    <= '0;
      sc_q    <= 1'b0;
      slast_q <= 1'b0;
    end else if (sub_en) begin
      sa_q    <= phys_addr;
      sl_q    <= cur_len;
      sc_q    <= phys_coh;
      slast_q <= part_q || !two_part;
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign lk_req      = (state_q == ST_LOOK) && in_win;
  assign lk_idx      = idx;
  assign sub_valid   = sv_q;
  assign sub_addr    = sa_q;
  assign sub_len     = sl_q;
  assign sub_write   = wr_q;
  assign sub_coh     = sc_q;
  assign sub_last    = slast_q;
  assign err_illegal = err_q;

endmodule

// File: rtl/xsplit_chk.sv
module xsplit_chk #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int LEN_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              sub_valid,
  input logic              sub_ready,
  input logic [ADDR_W-1:0] sub_addr,
  input logic [LEN_W-1:0]  sub_len,
  input logic              sub_coh,
  input logic              sub_last,
  input logic              err_illegal,
  input logic              lk_req
);

  localparam int EW = (PAGE_W + 2 > LEN_W + 1) ? PAGE_W + 2 : LEN_W + 1;

  logic [EW-1:0] end_off;
  assign end_off = EW'(sub_addr[PAGE_W-1:0]) + EW'(sub_len);

  // R9: offered payload is frozen under backpressure
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !sub_ready) |=> (sub_valid && $stable(sub_addr) &&
      $stable(sub_len) && $stable(sub_coh) && $stable(sub_last)));

  // R10: no new request while a sub-request is pending
  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> !req_ready);

  // R3: illegal flag only right after an accepting edge
  a_r3_err_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |-> $past(req_valid && req_ready));

  // R5: a sub-request never runs past its page end
  a_r5_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> (end_off <= EW'(1 << PAGE_W)));

  // R1: sub-request length is a non-zero multiple of 8
  a_r1_len_grain: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> ((sub_len[2:0] == 3'b000) && (sub_len != '0)));

  // R8: lookups are issued only while a request is in flight
  a_r8_lookup_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> (!req_ready && !sub_valid));

endmodule

bind xlat_splitter xsplit_chk #(
  .ADDR_W (ADDR_W),
  .PAGE_W (PAGE_W),
  .LEN_W  (LEN_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .sub_valid   (sub_valid),
  .sub_ready   (sub_ready),
  .sub_addr    (sub_addr),
  .sub_len     (sub_len),
  .sub_coh     (sub_coh),
  .sub_last    (sub_last),
  .err_illegal (err_illegal),
  .lk_req      (lk_req)
);

// File: tb/xlat_splitter_tb.sv
`timescale 1ns/1ps
module xlat_splitter_tb;

  localparam int ADDR_W = 32;
  localparam int PAGE_W = 12;
  localparam int LEN_W  = 9;
  localparam int VPN_W  = ADDR_W - PAGE_W;
  localparam int unsigned WIN = 32'h10000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              req_write = 1'b0;
  logic              sub_valid;
  logic              sub_ready = 1'b0;
  logic [ADDR_W-1:0] sub_addr;
  logic [LEN_W-1:0]  sub_len;
  logic              sub_write;
  logic              sub_coh;
  logic              sub_last;
  logic              err_illegal;
  logic              lk_req;
  logic [3:0]        lk_idx;
  logic [VPN_W-1:0]  lk_page = '0;
  logic              lk_coh = 1'b0;

  int checks = 0;
  int fails  = 0;
  int lk_count = 0;

  always #5 clk = ~clk;

  xlat_splitter u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write),
    .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_addr(sub_addr),
    .sub_len(sub_len), .sub_write(sub_write), .sub_coh(sub_coh),
    .sub_last(sub_last), .err_illegal(err_illegal),
    .lk_req(lk_req), .lk_idx(lk_idx), .lk_page(lk_page), .lk_coh(lk_coh)
  );

  // Table model: non-adjacent pages, alternating coherency
  function automatic logic [VPN_W-1:0] tbl_pg(input int i);
    return VPN_W'(32'hC0000 + i * 32'h113);
  endfunction
  function automatic logic tbl_ch(input int i);
    return (i % 2) == 0;
  endfunction

  always @(posedge clk) begin
    if (lk_req) begin
      lk_page  <= tbl_pg(int'(lk_idx));
      lk_coh   <= tbl_ch(int'(lk_idx));
      lk_count <= lk_count + 1;
    end
  end

  function automatic bit legal_len(input int n);
    return (n >= 8 && n <= 64 && n % 8 == 0) || (n >= 32 && n <= 256 && n % 32 == 0);
  endfunction

  function automatic bit in_win(input logic [ADDR_W-1:0] a);
    int unsigned p;
    p = a >> PAGE_W;
    return (p >= WIN) && (p < WIN + 16);
  endfunction

  function automatic logic [ADDR_W-1:0] xl_addr(input logic [ADDR_W-1:0] a);
    if (in_win(a)) return {tbl_pg(int'((a >> PAGE_W) - WIN)), a[PAGE_W-1:0]};
    return a;
  endfunction

  function automatic logic xl_coh(input logic [ADDR_W-1:0] a);
    if (in_win(a)) return tbl_ch(int'((a >> PAGE_W) - WIN));
    return 1'b1;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_req(input logic [ADDR_W-1:0] a, input int n, input logic wr);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr  = a;
    req_len   = LEN_W'(n);
    req_write = wr;
    req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // Drive a legal request and compare every sub-request against the model
  task automatic run_legal(input string tag, input logic [ADDR_W-1:0] a,
                           input int n, input logic wr, input int stall);
    int unsigned off;
    int room;
    int nparts;
    logic [ADDR_W-1:0] pa [2];
    int pl [2];
    off  = a[PAGE_W-1:0];
    room = 4096 - int'(off);
    if (n > room) begin
      nparts = 2; pa[0] = a; pl[0] = room;
      pa[1] = {a[ADDR_W-1:PAGE_W] + VPN_W'(1), 12'h000}; pl[1] = n - room;
    end else begin
      nparts = 1; pa[0] = a; pl[0] = n; pa[1] = '0; pl[1] = 0;
    end
    send_req(a, n, wr);
    for (int k = 0; k < nparts; k++) begin
      int wait_n;
      wait_n = 0;
      @(negedge clk);
      while (!sub_valid && wait_n < 20) begin
        check({tag, " R10 busy"}, req_ready, 1'b0);
        @(negedge clk);
        wait_n++;
      end
      check({tag, " sub_valid"}, sub_valid, 1'b1);
      check({tag, " R10 ready low"}, req_ready, 1'b0);
      check({tag, " addr"}, sub_addr, xl_addr(pa[k]));
      check({tag, " len"}, sub_len, pl[k]);
      check({tag, " coh"}, sub_coh, xl_coh(pa[k]));
      check({tag, " last"}, sub_last, (k == nparts - 1));
      check({tag, " R10 write echo"}, sub_write, wr);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        check({tag, " R9 hold valid"}, sub_valid, 1'b1);
        check({tag, " R9 hold addr"}, sub_addr, xl_addr(pa[k]));
        check({tag, " R9 hold len"}, sub_len, pl[k]);
        check({tag, " R9 hold coh"}, sub_coh, xl_coh(pa[k]));
        check({tag, " R9 hold last"}, sub_last, (k == nparts - 1));
      end
      sub_ready = 1'b1;
      @(posedge clk);
      #1 sub_ready = 1'b0;
    end
    @(negedge clk);
    check({tag, " done ready"}, req_ready, 1'b1);
    check({tag, " no extra sub"}, sub_valid, 1'b0);
  endtask

  task automatic run_illegal(input string tag, input logic [ADDR_W-1:0] a, input int n);
    int lk0;
    lk0 = lk_count;
    send_req(a, n, 1'b0);
    @(negedge clk);
    check({tag, " R3 err pulse"}, err_illegal, 1'b1);
    check({tag, " R3 no sub"}, sub_valid, 1'b0);
    check({tag, " R3 ready"}, req_ready, 1'b1);
    repeat (4) begin
      @(negedge clk);
      check({tag, " R3 quiet"}, {sub_valid, err_illegal}, 2'b00);
    end
    check({tag, " R3 no lookup"}, lk_count, lk0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R11 req_ready", req_ready, 1'b1);
    check("R11 sub_valid", sub_valid, 1'b0);
    check("R11 err_illegal", err_illegal, 1'b0);
    check("R11 lk_req", lk_req, 1'b0);
  endtask

  task automatic t_sizes;
    // R1: legal set sweep (fine, coarse, both grains)
    run_legal("R1 len8",   32'h1000_3000, 8,   1'b0, 0);
    run_legal("R1 len40",  32'h1000_3100, 40,  1'b1, 0);
    run_legal("R1 len96",  32'h1000_3200, 96,  1'b0, 0);
    run_legal("R1 len256", 32'h1000_3400, 256, 1'b0, 0);
    run_illegal("R1 len0",   32'h1000_3000, 0);
    run_illegal("R1 len12",  32'h1000_3000, 12);
    run_illegal("R1 len72",  32'h1000_3000, 72);
    run_illegal("R1 len200", 32'h1000_3000, 200);
    run_illegal("R1 len288", 32'h1000_3000, 288);
  endtask

  task automatic t_align;
    run_illegal("R2 addr+4", 32'h1000_3004, 8);
    run_illegal("R2 addr+1", 32'h0000_5001, 64);
    run_legal("R2 addr+8", 32'h1000_3008, 16, 1'b0, 0);
  endtask

  task automatic t_single;
    run_legal("R4 R6 fit", 32'h1000_5040, 64, 1'b1, 0);
    run_legal("R4 exact end", 32'h1000_5FC0, 64, 1'b0, 0);
  endtask

  task automatic t_cross;
    run_legal("R5 R7 cross8", 32'h1000_1FF8, 16, 1'b0, 0);
    run_legal("R5 R7 cross256", 32'h1000_7FC0, 256, 1'b1, 0);
    run_legal("R5 one below", 32'h1000_2FF8, 256, 1'b0, 0);
  endtask

  task automatic t_bypass;
    int lk0;
    lk0 = lk_count;
    run_legal("R8 bypass cross", 32'h0000_2FF0, 64, 1'b0, 0);
    check("R8 no lookup", lk_count, lk0);
    run_legal("R8 above window", 32'h1001_0100, 32, 1'b1, 0);
    run_legal("R7 R8 window edge", 32'h1000_FFE0, 64, 1'b0, 0);
    run_legal("R7 R8 below window", 32'h0FFF_FFF8, 32, 1'b0, 0);
  endtask

  task automatic t_stall;
    run_legal("R9 stall cross", 32'h1000_4FE0, 128, 1'b1, 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_sizes();
    t_align();
    t_single();
    t_cross();
    t_bypass();
    t_stall();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule